// File: doc/BRIEF.md
# SD Host Clock Preset Selector

This block holds a small table of clock presets for an SD host controller and decides which preset, if any, governs the SD clock. Each of the eight 16-bit entries stores a clock-generator select flag and a 10-bit SD clock divider value. Software reaches the table through a simple byte-addressed register port. Writes are accepted only while the capabilities write enable is high. Reads are always allowed.

The bus-speed-mode control bits pick the active entry: the 1.8V signalling flag, the high-speed flag and the 3-bit UHS mode field. When preset mode is enabled and the decode lands on a defined entry, that entry's fields replace the software-programmed clock control fields on the effective outputs. In every other case the software fields pass through unchanged. Entry 0 is the initialization preset. It is stored and readable, but the speed decode never selects it. The effective fields are registered.

Top module: `sdclk_preset_sel`

## Requirements
- R1: While and after reset, all eight entries read 0x0000 and both effective outputs are 0.
- R2: In an entry, bit 10 is the clock-generator select and bits 9:0 are the divider. Bits 15:11 are not stored and always read as 0.
- R3: Entry x sits at byte address 0x60 + 2*x for x = 0..7. A read returns the stored value combinationally, whatever the capabilities write enable is.
- R4: A write to an entry is stored only when cap_wr_en is 1. With cap_wr_en at 0, the write leaves the table unchanged.
- R5: An access that falls outside the window is ignored, and its read returns 0. This covers addresses below 0x60, above 0x6E, and odd addresses.
- R6: With sig18_en=0 and hs_en=0, entry 1 is selected, whatever uhs_mode holds.
- R7: With sig18_en=0 and hs_en=1, entry 2 is selected, whatever uhs_mode holds.
- R8: With sig18_en=1, hs_en is a don't-care. A uhs_mode value m in 0..4 selects entry m+3. Values 5..7 are reserved, and for them the software fields pass through.
- R9: Entry 0 is never selected. With preset_en=0, the effective outputs equal sw_clk_gen_sel and sw_clk_div.
- R10: With preset_en=1 and a defined selection, the effective outputs equal the selected entry, and changes on the software fields have no effect.
- R11: The effective outputs change one clock after any change in the mode bits, preset_en, the software fields or the selected entry's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| cap_wr_en | input | 1 | Allows writes to the preset table |
| preset_en | input | 1 | Preset mode: table drives the effective clock fields |
| sig18_en | input | 1 | 1.8V signalling enable |
| hs_en | input | 1 | High-speed enable |
| uhs_mode | input | 3 | UHS mode field |
| sw_clk_gen_sel | input | 1 | Software clock-generator select |
| sw_clk_div | input | 10 | Software SD clock divider |
| eff_clk_gen_sel | output | 1 | Effective clock-generator select (registered) |
| eff_clk_div | output | 10 | Effective SD clock divider (registered) |

## Verification
The assertions take two things for granted:
- rst_n is released away from a clock edge.
- Every input is stable around the rising edge, so a value held during a cycle is the value sampled.

The follow and pass-through properties compare the output with the inputs of one cycle earlier, so they also assume that nothing other than those inputs moves the effective fields. The bench changes every input only on the falling edge and issues each write as a single-cycle strobe. It leaves reg_addr unchanged across the edge that writes.

// File: rtl/sdpre_pkg.sv
package sdpre_pkg;
  localparam int DIV_W   = 10;
  localparam int ENTRY_W = DIV_W + 1;
  localparam int DATA_W  = 16;

  typedef struct packed {
    logic             gen_sel;
    logic [DIV_W-1:0] div;
  } clk_fields_t;
endpackage

// File: rtl/sdpre_table.sv
module sdpre_table
  import sdpre_pkg::*;
#(
  parameter int                NUM    = 8,
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h60,
  localparam int               IDX_W  = $clog2(NUM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr,
  input  logic [ENTRY_W-1:0]     wdata,
  input  logic                   cap_wr_en,
  output logic [DATA_W-1:0]      rdata,
  output clk_fields_t [NUM-1:0]  entries
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(2 * NUM);

  logic [ADDR_W-1:0] offs;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              we;

  assign offs = addr - BASE;
  assign hit  = (addr >= BASE) && ({1'b0, offs} < SPAN) && !offs[0];
  assign idx  = offs[IDX_W:1];
  assign we   = wr && cap_wr_en && hit;

  // one clock enable per entry
  for (genvar i = 0; i < NUM; i++) begin : g_entry
    logic ce;
    assign ce = we && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  entries[i] <= '0;
      else if (ce) entries[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = {{(DATA_W-ENTRY_W){1'b0}}, entries[idx]};
  end

  p_wr_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !cap_wr_en) |=> $stable(entries));
  p_wr_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cap_wr_en && hit) |=> (entries[$past(idx)] == $past(wdata)));
  p_miss_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> $stable(entries));
endmodule

// File: rtl/sdpre_mode_dec.sv
module sdpre_mode_dec #(
  parameter int  NUM      = 8,
  parameter int  UHS_W    = 3,
  parameter int  UHS_MAX  = 4,
  parameter int  UHS_BASE = 3,
  localparam int IDX_W    = $clog2(NUM)
) (
  input  logic             sig18_en,
  input  logic             hs_en,
  input  logic [UHS_W-1:0] uhs_mode,
  output logic [IDX_W-1:0] sel_idx,
  output logic             sel_valid
);
  localparam int IDX_DEF = 1;
  localparam int IDX_HS  = 2;

  always_comb begin
    sel_idx   = '0;
    sel_valid = 1'b0;
    if (!sig18_en) begin
      sel_valid = 1'b1;
      sel_idx   = hs_en ? IDX_W'(IDX_HS) : IDX_W'(IDX_DEF);
    end else if (uhs_mode <= UHS_W'(UHS_MAX)) begin
      sel_valid = 1'b1;
      sel_idx   = IDX_W'(uhs_mode) + IDX_W'(UHS_BASE);
    end
  end
endmodule

// File: rtl/sdpre_out_stage.sv
module sdpre_out_stage
  import sdpre_pkg::*;
#(
  parameter int  NUM   = 8,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  clk_fields_t [NUM-1:0] entries,
  input  logic [IDX_W-1:0]      sel_idx,
  input  logic                  sel_valid,
  input  logic                  preset_en,
  input  clk_fields_t           sw_fields,
  output clk_fields_t           eff_q
);
  clk_fields_t eff_d;
  logic        upd;

  always_comb begin
    eff_d = sw_fields;
    if (preset_en && sel_valid) eff_d = entries[sel_idx];
  end

  assign upd = (eff_d != eff_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   eff_q <= '0;
    else if (upd) eff_q <= eff_d;
  end

  p_pass_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_en |=> (eff_q == $past(sw_fields)));
  p_pass_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_en && !sel_valid) |=> (eff_q == $past(sw_fields)));
  p_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_en && sel_valid) |=> (eff_q == $past(entries[sel_idx])));
endmodule

// File: rtl/sdclk_preset_sel.sv
module sdclk_preset_sel
  import sdpre_pkg::*;
#(
  parameter int                NUM    = 8,
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h60,
  parameter int                UHS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cap_wr_en,
  input  logic              preset_en,
  input  logic              sig18_en,
  input  logic              hs_en,
  input  logic [UHS_W-1:0]  uhs_mode,
  input  logic              sw_clk_gen_sel,
  input  logic [DIV_W-1:0]  sw_clk_div,
  output logic              eff_clk_gen_sel,
  output logic [DIV_W-1:0]  eff_clk_div
);
  localparam int                IDX_W = $clog2(NUM);
  localparam logic [ADDR_W-1:0] LAST  = BASE + ADDR_W'(2 * (NUM - 1));

  clk_fields_t [NUM-1:0] entries;
  clk_fields_t           sw_fields;
  clk_fields_t           eff;
  logic [IDX_W-1:0]      sel_idx;
  logic                  sel_valid;
  logic                  unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:ENTRY_W];
  assign sw_fields       = '{gen_sel: sw_clk_gen_sel, div: sw_clk_div};

  sdpre_table #(.NUM(NUM), .ADDR_W(ADDR_W), .BASE(BASE)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (reg_addr),
    .wr        (reg_wr),
    .wdata     (reg_wdata[ENTRY_W-1:0]),
    .cap_wr_en (cap_wr_en),
    .rdata     (reg_rdata),
    .entries   (entries)
  );

  sdpre_mode_dec #(.NUM(NUM), .UHS_W(UHS_W)) u_dec (
    .sig18_en  (sig18_en),
    .hs_en     (hs_en),
    .uhs_mode  (uhs_mode),
    .sel_idx   (sel_idx),
    .sel_valid (sel_valid)
  );

  sdpre_out_stage #(.NUM(NUM)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .entries   (entries),
    .sel_idx   (sel_idx),
    .sel_valid (sel_valid),
    .preset_en (preset_en),
    .sw_fields (sw_fields),
    .eff_q     (eff)
  );

  assign eff_clk_gen_sel = eff.gen_sel;
  assign eff_clk_div     = eff.div;

  p_no_init_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_idx != '0));
  p_outside_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < BASE || reg_addr > LAST || reg_addr[0]) |-> (reg_rdata == '0));
endmodule

// File: tb/sdclk_preset_sel_bench.sv
`timescale 1ns/1ps
module sdclk_preset_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        cap_wr_en, preset_en, sig18_en, hs_en;
  logic [2:0]  uhs_mode;
  logic        sw_clk_gen_sel;
  logic [9:0]  sw_clk_div;
  logic        eff_clk_gen_sel;
  logic [9:0]  eff_clk_div;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  sdclk_preset_sel u_sdclk_preset_sel (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_wr_en(cap_wr_en),
    .preset_en(preset_en), .sig18_en(sig18_en), .hs_en(hs_en),
    .uhs_mode(uhs_mode), .sw_clk_gen_sel(sw_clk_gen_sel), .sw_clk_div(sw_clk_div),
    .eff_clk_gen_sel(eff_clk_gen_sel), .eff_clk_div(eff_clk_div)
  );

  // {sig18, hs, uhs[2:0], preset_en, sw_gs, sw_div[9:0], expected entry (8 = pass)}
  localparam logic [20:0] VEC [13] = '{
    {1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 10'h011, 4'd1},
    {1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 10'h022, 4'd2},
    {1'b0, 1'b0, 3'd5, 1'b1, 1'b1, 10'h033, 4'd1},
    {1'b0, 1'b1, 3'd7, 1'b1, 1'b1, 10'h044, 4'd2},
    {1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 10'h055, 4'd3},
    {1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 10'h066, 4'd4},
    {1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 10'h077, 4'd5},
    {1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 10'h088, 4'd6},
    {1'b1, 1'b0, 3'd4, 1'b1, 1'b1, 10'h099, 4'd7},
    {1'b1, 1'b0, 3'd5, 1'b1, 1'b1, 10'h155, 4'd8},
    {1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 10'h2AA, 4'd8},
    {1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 10'h3C3, 4'd8},
    {1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 10'h099, 4'd8}
  };

  // preset value programmed into entry i
  function automatic logic [10:0] pv(int i);
    logic [9:0] d;
    d = 10'(i * 37 + 5);
    return {i[0], d};
  endfunction

  function automatic logic [15:0] eff_now();
    return {5'b0, eff_clk_gen_sel, eff_clk_div};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = 8'h60; reg_wr = 1'b0; reg_wdata = '0;
    cap_wr_en = 1'b0; preset_en = 1'b1; sig18_en = 1'b0; hs_en = 1'b0;
    uhs_mode = 3'd0; sw_clk_gen_sel = 1'b1; sw_clk_div = 10'h3FF;
    #9;
    // R1: reset state
    chk("R1 eff during reset", eff_now(), 16'h0000);
    reg_addr = 8'h66;
    #1 chk("R1 entry3 during reset", reg_rdata, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) rd_chk("R1 entry after reset", 8'(8'h60 + 2 * i), 16'h0000);

    // program table, upper garbage bits must not stick (R2)
    cap_wr_en = 1'b1;
    for (int i = 0; i < 8; i++) wr(8'(8'h60 + 2 * i), {5'b10101, pv(i)});
    cap_wr_en = 1'b0;
    // R3: read back with cap_wr_en low; R2: bits 15:11 zero
    for (int i = 0; i < 8; i++) rd_chk("R3 R2 readback", 8'(8'h60 + 2 * i), {5'b0, pv(i)});

    // vector walk
    for (int k = 0; k < 13; k++) begin
      logic [20:0] v;
      logic [15:0] exp;
      string tag;
      v = VEC[k];
      @(negedge clk);
      sig18_en = v[20]; hs_en = v[19]; uhs_mode = v[18:16]; preset_en = v[15];
      sw_clk_gen_sel = v[14]; sw_clk_div = v[13:4];
      if (v[3:0] == 4'd8) exp = {5'b0, v[14], v[13:4]};
      else exp = {5'b0, pv(int'(v[3:0]))};
      if (!v[15]) tag = "R9 preset off";
      else if (v[3:0] == 4'd1) tag = "R6 default speed";
      else if (v[3:0] == 4'd2) tag = "R7 high speed";
      else tag = "R8 uhs decode";
      @(posedge clk); #1;
      chk(tag, eff_now(), exp);
    end

    // R10: software fields ignored when preset selects entry 2
    @(negedge clk);
    preset_en = 1'b1; sig18_en = 1'b0; hs_en = 1'b1;
    @(negedge clk);
    sw_clk_gen_sel = ~sw_clk_gen_sel; sw_clk_div = 10'h1E7;
    @(posedge clk); #1 chk("R10 sw ignored", eff_now(), {5'b0, pv(2)});

    // R11: mode change visible one clock later
    @(negedge clk);
    hs_en = 1'b0;
    #1 chk("R11 before edge", eff_now(), {5'b0, pv(2)});
    @(posedge clk); #1 chk("R11 after edge", eff_now(), {5'b0, pv(1)});

    // R11: content change of selected entry takes two edges (write, then output)
    @(negedge clk);
    cap_wr_en = 1'b1; reg_addr = 8'h62; reg_wdata = 16'h0555; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; cap_wr_en = 1'b0;
    #1 chk("R11 content edge1", eff_now(), {5'b0, pv(1)});
    @(posedge clk); #1 chk("R11 content edge2", eff_now(), 16'h0555);

    // R4: blocked write
    wr(8'h68, 16'h0123);
    rd_chk("R4 blocked write", 8'h68, {5'b0, pv(4)});

    // R5: out-of-window and odd writes ignored, reads zero
    cap_wr_en = 1'b1;
    wr(8'h5E, 16'h07FF);
    wr(8'h70, 16'h07FF);
    wr(8'h63, 16'h07FF);
    cap_wr_en = 1'b0;
    rd_chk("R5 below window", 8'h5E, 16'h0000);
    rd_chk("R5 above window", 8'h70, 16'h0000);
    rd_chk("R5 odd address", 8'h63, 16'h0000);
    rd_chk("R5 entry0 intact", 8'h60, {5'b0, pv(0)});
    rd_chk("R5 entry1 intact", 8'h62, 16'h0555);
    rd_chk("R5 entry7 intact", 8'h6E, {5'b0, pv(7)});

    // R9: entry 0 not selected by any mode with preset on
    cap_wr_en = 1'b1;
    wr(8'h60, 16'h07AB);
    cap_wr_en = 1'b0;
    preset_en = 1'b1;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      sig18_en = m[3]; hs_en = m[2]; uhs_mode = {1'b0, m[1:0]} + 3'(m[3] & m[2]) * 3'd4;
      sw_clk_gen_sel = 1'b0; sw_clk_div = 10'h000;
      @(posedge clk); #1;
      n_tests++;
      if (eff_now() === 16'h07AB) begin
        n_fail++;
        $display("FAIL R9 entry0 selected actual=%h expected=not 07ab", eff_now());
      end
    end

    finish_run();
  end
endmodule